// File: doc/BRIEF.md
# Dot Clock PLL Coefficient Search Engine

This block picks the three settings of a pixel-clock PLL (feedback count M, reference count N and a post-VCO divider byte) that bring a fixed 14,318,180 Hz reference as close as possible to a requested frequency. The caller presents the wanted frequency in Hz as a 32-bit integer together with a one-cycle start pulse. Targets outside the PLL's reach are refused at once. Otherwise the engine doubles the target into the VCO band and divides it by the reference to get a quotient and a remainder. It then walks N from 3 to 257, one candidate per clock, and keeps the candidate with the smallest absolute error. At the end it returns register-ready codes.

The error of each candidate is never formed from a wide product. The sweep carries the running remainder of N·F/Fref from one N to the next and adds the quotient to M on each step, so the exact error falls out of that remainder. When M is above 257, the bits that a divide-by-4 feedback path would lose are added to the error. The controller is a five-state machine. ST_IDLE waits for start. It either refuses the target (it pulses done with the range flag and stays) or moves to ST_SCALE. ST_SCALE doubles until the value reaches 100 MHz, then loads the divider and moves to ST_DIVIDE. ST_DIVIDE waits for the quotient to settle and clears the best-so-far record, then moves to ST_SWEEP. ST_SWEEP steps N and moves to ST_FINISH after N = 257. ST_FINISH encodes the result, pulses done and returns to ST_IDLE.

Top module: `dclk_coef_search`

## Requirements
- R1: After reset, done, busy and range_err are 0, and m_code, n_code and div_code are 0.
- R2: A start seen while busy is 0, with target_hz below 3,125,000 or above 220,000,000, gives done = 1 and range_err = 1 in the very next cycle. busy stays 0 and all three codes read 0.
- R3: A start seen while busy is 0, with target_hz inside 3,125,000..220,000,000 inclusive, raises busy in the next cycle. The run ends with a done pulse exactly one cycle wide, with range_err = 0 and busy = 0.
- R4: Bits 7:4 of div_code count how many times the target was doubled before it reached at least 100,000,000. The count is 0 to 5: a target of 3,125,000 gives 5 and a target of 100,000,000 gives 0.
- R5: With F the scaled target, every N from 3 to 257 is a candidate, with M = floor(N·F / 14,318,180). When 3 <= M <= 257 its error is N·F − 14,318,180·M. A candidate replaces the best only when its error is strictly smaller, so the lowest N wins a tie.
- R6: When 257 < M <= 1028, the candidate's error is computed with the two low bits of M cleared. Candidates with M above 1028 are skipped.
- R7: n_code is best N − 2. If best M <= 257, m_code is M − 2 and div_code bit 2 is 1. Otherwise m_code is (M >> 2) − 2 and bit 2 is 0. Bits 3, 1 and 0 of div_code are always 0.
- R8: While busy, start and target_hz are ignored. The result is the one for the target taken when the run began.
- R9: m_code, n_code, div_code and range_err change only in a cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; taken only when busy is 0 |
| target_hz | input | 32 | Requested frequency in Hz, sampled with start |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse when the result or the refusal is ready |
| range_err | output | 1 | Set with done when the target was refused |
| m_code | output | 8 | Encoded feedback count |
| n_code | output | 8 | Encoded reference count |
| div_code | output | 8 | Post-divider count in bits 7:4, loop-divide-of-one select in bit 2 |

## Verification
The properties assume that target_hz is meaningful only in a cycle where start is high and busy is low. They also assume that start is not raised in the cycle where done is already up, since the one-cycle-pulse property treats a back-to-back refusal as a separate event. The bench drives start for exactly one cycle from the falling edge, changes target_hz to unrelated values once the request is taken, and waits for the done pulse before issuing the next request, except in the deliberate mid-run restart case.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int unsigned REF_HZ_DEF   = 32'd14318180;
    localparam int unsigned MIN_HZ_DEF   = 32'd3125000;
    localparam int unsigned MAX_HZ_DEF   = 32'd220000000;
    localparam int unsigned FLOOR_HZ_DEF = 32'd100000000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE,
        ST_DIVIDE,
        ST_SWEEP,
        ST_FINISH
    } dclk_state_e;

endpackage

// File: rtl/dclk_quot_unit.sv
module dclk_quot_unit #(
    parameter int unsigned DIVISOR = 32'd14318180,
    parameter int          FT_W    = 32,
    parameter int          QW      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [FT_W-1:0] dividend,
    output logic [QW-1:0]   quo,
    output logic [FT_W-1:0] rem,
    output logic            ready
);
    localparam logic [FT_W-1:0] DIV_V = FT_W'(DIVISOR);

    logic [FT_W-1:0] rem_q;
    logic [QW-1:0]   quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= dividend;
            quo_q <= '0;
        end else if (rem_q >= DIV_V) begin
            rem_q <= rem_q - DIV_V;
            quo_q <= quo_q + QW'(1);
        end
    end

    assign ready = (rem_q < DIV_V);
    assign quo   = quo_q;
    assign rem   = rem_q;
endmodule

// File: rtl/dclk_cand_step.sv
module dclk_cand_step #(
    parameter int unsigned REF_HZ  = 32'd14318180,
    parameter int          FT_W    = 32,
    parameter int          QW      = 5,
    parameter int          MW      = 13,
    parameter int          NW      = 9,
    parameter int          ERR_W   = 40,
    parameter int unsigned N_FIRST = 3,
    parameter int unsigned M_LOW   = 3,
    parameter int unsigned M_HIGH  = 257,
    parameter int unsigned M_FOLD  = 1028
) (
    input  logic [NW-1:0]    n_cur,
    input  logic [MW-1:0]    m_cur,
    input  logic [FT_W-1:0]  acc_cur,
    input  logic [QW-1:0]    quo,
    input  logic [FT_W-1:0]  rem,
    output logic [MW-1:0]    m_nxt,
    output logic [FT_W-1:0]  acc_nxt,
    output logic             cand_ok,
    output logic [ERR_W-1:0] cand_err
);
    localparam logic [FT_W:0] REF_W = (FT_W+1)'(REF_HZ);

    logic [FT_W:0] sum;
    logic          carry;

    always_comb begin
        sum     = {1'b0, acc_cur} + {1'b0, rem};
        carry   = (sum >= REF_W);
        acc_nxt = carry ? FT_W'(sum - REF_W) : sum[FT_W-1:0];
        m_nxt   = m_cur + MW'(quo) + MW'(carry);
    end

    always_comb begin
        cand_ok = (n_cur >= NW'(N_FIRST)) && (m_cur >= MW'(M_LOW))
                  && (m_cur <= MW'(M_FOLD));
        if (m_cur <= MW'(M_HIGH))
            cand_err = ERR_W'(acc_cur);
        else
            cand_err = ERR_W'(acc_cur) + ERR_W'(REF_HZ) * ERR_W'(m_cur[1:0]);
    end
endmodule

// File: rtl/dclk_best_track.sv
module dclk_best_track #(
    parameter int MW    = 13,
    parameter int NW    = 9,
    parameter int ERR_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_en,
    input  logic [ERR_W-1:0] cand_err,
    input  logic [MW-1:0]    cand_m,
    input  logic [NW-1:0]    cand_n,
    output logic [MW-1:0]    best_m,
    output logic [NW-1:0]    best_n
);
    logic [ERR_W-1:0] best_err_q;
    logic [MW-1:0]    best_m_q;
    logic [NW-1:0]    best_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_err_q <= '1;
            best_m_q   <= '0;
            best_n_q   <= '0;
        end else if (clr) begin
            best_err_q <= '1;
            best_m_q   <= '0;
            best_n_q   <= '0;
        end else if (upd_en && (cand_err < best_err_q)) begin
            best_err_q <= cand_err;
            best_m_q   <= cand_m;
            best_n_q   <= cand_n;
        end
    end

    assign best_m = best_m_q;
    assign best_n = best_n_q;
endmodule

// File: rtl/dclk_coef_search.sv
module dclk_coef_search
    import dclk_pkg::*;
#(
    parameter int unsigned REF_HZ   = REF_HZ_DEF,
    parameter int unsigned MIN_HZ   = MIN_HZ_DEF,
    parameter int unsigned MAX_HZ   = MAX_HZ_DEF,
    parameter int unsigned FLOOR_HZ = FLOOR_HZ_DEF,
    parameter int unsigned N_FIRST  = 3,
    parameter int unsigned N_LAST   = 257,
    parameter int unsigned M_LOW    = 3,
    parameter int unsigned M_HIGH   = 257,
    parameter int unsigned M_FOLD   = 1028,
    parameter int          FT_W     = 32,
    parameter int          CODE_W   = 8,
    parameter int          QW       = 5,
    parameter int          MW       = 13,
    parameter int          NW       = 9,
    parameter int          ERR_W    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FT_W-1:0]   target_hz,
    output logic              busy,
    output logic              done,
    output logic              range_err,
    output logic [CODE_W-1:0] m_code,
    output logic [CODE_W-1:0] n_code,
    output logic [CODE_W-1:0] div_code
);
    localparam logic [CODE_W-1:0] DIV_STEP  = CODE_W'(8'h10);
    localparam logic [CODE_W-1:0] LOOP1_SEL = CODE_W'(8'h04);
    localparam logic [FT_W-1:0]   FLOOR_V   = FT_W'(FLOOR_HZ);

    dclk_state_e state_q, state_d;

    logic [FT_W-1:0]   ft_q;
    logic [CODE_W-1:0] div_q;
    logic [NW-1:0]     n_q;
    logic [MW-1:0]     m_q;
    logic [FT_W-1:0]   acc_q;

    logic              in_range;
    logic              qu_load;
    logic [QW-1:0]     qu_quo;
    logic [FT_W-1:0]   qu_rem;
    logic              qu_ready;
    logic [MW-1:0]     m_nxt;
    logic [FT_W-1:0]   acc_nxt;
    logic              cand_ok;
    logic [ERR_W-1:0]  cand_err;
    logic [MW-1:0]     best_m;
    logic [NW-1:0]     best_n;
    logic [MW-1:0]     best_m_qtr;

    assign in_range   = (target_hz >= FT_W'(MIN_HZ)) && (target_hz <= FT_W'(MAX_HZ));
    assign qu_load    = (state_q == ST_SCALE) && (ft_q >= FLOOR_V);
    assign busy       = (state_q != ST_IDLE);
    assign best_m_qtr = best_m >> 2;

    dclk_quot_unit #(
        .DIVISOR (REF_HZ),
        .FT_W    (FT_W),
        .QW      (QW)
    ) u_quot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (qu_load),
        .dividend (ft_q),
        .quo      (qu_quo),
        .rem      (qu_rem),
        .ready    (qu_ready)
    );

    dclk_cand_step #(
        .REF_HZ  (REF_HZ),
        .FT_W    (FT_W),
        .QW      (QW),
        .MW      (MW),
        .NW      (NW),
        .ERR_W   (ERR_W),
        .N_FIRST (N_FIRST),
        .M_LOW   (M_LOW),
        .M_HIGH  (M_HIGH),
        .M_FOLD  (M_FOLD)
    ) u_step (
        .n_cur    (n_q),
        .m_cur    (m_q),
        .acc_cur  (acc_q),
        .quo      (qu_quo),
        .rem      (qu_rem),
        .m_nxt    (m_nxt),
        .acc_nxt  (acc_nxt),
        .cand_ok  (cand_ok),
        .cand_err (cand_err)
    );

    dclk_best_track #(
        .MW    (MW),
        .NW    (NW),
        .ERR_W (ERR_W)
    ) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_DIVIDE),
        .upd_en   ((state_q == ST_SWEEP) && cand_ok),
        .cand_err (cand_err),
        .cand_m   (m_q),
        .cand_n   (n_q),
        .best_m   (best_m),
        .best_n   (best_n)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && in_range)          state_d = ST_SCALE;
            ST_SCALE:  if (ft_q >= FLOOR_V)            state_d = ST_DIVIDE;
            ST_DIVIDE: if (qu_ready)                   state_d = ST_SWEEP;
            ST_SWEEP:  if (n_q == NW'(N_LAST))         state_d = ST_FINISH;
            ST_FINISH:                                 state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ft_q      <= '0;
            div_q     <= '0;
            n_q       <= '0;
            m_q       <= '0;
            acc_q     <= '0;
            done      <= 1'b0;
            range_err <= 1'b0;
            m_code    <= '0;
            n_code    <= '0;
            div_code  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (in_range) begin
                            ft_q  <= target_hz;
                            div_q <= '0;
                        end else begin
                            done      <= 1'b1;
                            range_err <= 1'b1;
                            m_code    <= '0;
                            n_code    <= '0;
                            div_code  <= '0;
                        end
                    end
                end
                ST_SCALE: begin
                    if (ft_q < FLOOR_V) begin
                        ft_q  <= ft_q << 1;
                        div_q <= div_q + DIV_STEP;
                    end
                end
                ST_DIVIDE: begin
                    n_q   <= '0;
                    m_q   <= '0;
                    acc_q <= '0;
                end
                ST_SWEEP: begin
                    n_q   <= n_q + NW'(1);
                    m_q   <= m_nxt;
                    acc_q <= acc_nxt;
                end
                ST_FINISH: begin
                    done      <= 1'b1;
                    range_err <= 1'b0;
                    n_code    <= CODE_W'(best_n - NW'(2));
                    if (best_m > MW'(M_HIGH)) begin
                        m_code   <= CODE_W'(best_m_qtr - MW'(2));
                        div_code <= div_q;
                    end else begin
                        m_code   <= CODE_W'(best_m - MW'(2));
                        div_code <= div_q | LOOP1_SEL;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dclk_coef_search_chk.sv
module dclk_coef_search_chk #(
    parameter int unsigned MIN_HZ = 32'd3125000,
    parameter int unsigned MAX_HZ = 32'd220000000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] target_hz,
    input logic        busy,
    input logic        done,
    input logic        range_err,
    input logic [7:0]  m_code,
    input logic [7:0]  n_code,
    input logic [7:0]  div_code
);
    logic tgt_bad;
    assign tgt_bad = (target_hz < MIN_HZ) || (target_hz > MAX_HZ);

    a_r2_reject_next: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && tgt_bad) |=> (done && range_err && !busy));

    a_r2_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && range_err) |-> (m_code == 8'd0 && n_code == 8'd0 && div_code == 8'd0));

    a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !tgt_bad) |=> (busy && !done));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r4_scale_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !range_err) |-> (div_code[7:4] <= 4'd5));

    a_r7_div_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !range_err) |-> (div_code[3] == 1'b0 && div_code[1:0] == 2'b00));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    a_r9_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(m_code) && $stable(n_code) && $stable(div_code)
                   && $stable(range_err)));
endmodule

bind dclk_coef_search dclk_coef_search_chk #(
    .MIN_HZ (MIN_HZ),
    .MAX_HZ (MAX_HZ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .target_hz (target_hz),
    .busy      (busy),
    .done      (done),
    .range_err (range_err),
    .m_code    (m_code),
    .n_code    (n_code),
    .div_code  (div_code)
);

// File: tb/dclk_coef_search_bench.sv
module dclk_coef_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_hz = 32'd0;
    logic        busy, done, range_err;
    logic [7:0]  m_code, n_code, div_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dclk_coef_search u_dclk_coef_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .target_hz (target_hz),
        .busy      (busy),
        .done      (done),
        .range_err (range_err),
        .m_code    (m_code),
        .n_code    (n_code),
        .div_code  (div_code)
    );

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns {reject, m, n, div}
    function automatic logic [24:0] model(input logic [31:0] tgt);
        longint unsigned fref = 64'd14318180;
        longint unsigned ft = 64'(tgt);
        longint unsigned best_e = 64'hFFFF_FFFF_FFFF_FFFF;
        longint unsigned bm = 0, bn = 0;
        logic [7:0] d = 8'd0;
        logic [7:0] mo, no;
        if (tgt < 32'd3125000 || tgt > 32'd220000000) return {1'b1, 24'd0};
        while (ft < 64'd100000000) begin
            ft = ft * 2;
            d  = d + 8'h10;
        end
        for (int n = 3; n <= 257; n++) begin
            longint unsigned m = (ft * 64'(n)) / fref;
            longint unsigned e = 0;
            bit ok = 1'b0;
            if (m >= 3 && m <= 257) begin
                e = ft * 64'(n) - fref * m;
                ok = 1'b1;
            end else if (m > 257 && m <= 1028) begin
                e = ft * 64'(n) - fref * (m & ~64'd3);
                ok = 1'b1;
            end
            if (ok && e < best_e) begin
                best_e = e;
                bm = m;
                bn = 64'(n);
            end
        end
        if (bm > 257) begin
            mo = 8'((bm >> 2) - 2);
        end else begin
            mo = 8'(bm - 2);
            d  = d | 8'h04;
        end
        no = 8'(bn - 2);
        return {1'b0, mo, no, d};
    endfunction

    task automatic run_case(input logic [31:0] tgt, input bit interfere,
                            input logic [31:0] other);
        logic [24:0] e = model(tgt);
        int wait_cnt = 0;
        @(negedge clk);
        target_hz = tgt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        target_hz = $urandom;
        if (e[24]) begin
            chk(done && range_err && !busy, "R2 refuse flags",
                {done, range_err, busy}, 3'b110);
            chk(m_code == 0 && n_code == 0 && div_code == 0, "R2 zero codes",
                {m_code, n_code, div_code}, 0);
            @(negedge clk);
            chk(!done, "R2 done width", done, 0);
        end else begin
            chk(busy && !done, "R3 busy after start", {busy, done}, 2'b10);
            if (interfere) begin
                repeat (20) @(negedge clk);
                target_hz = other;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                target_hz = $urandom;
            end
            while (!done && wait_cnt < 2000) begin
                @(negedge clk);
                wait_cnt++;
            end
            chk(done == 1'b1, "R3 run completes", done, 1);
            chk(!range_err && !busy, "R3 flags at done", {range_err, busy}, 0);
            chk(div_code[7:4] == e[7:4], "R4 doubling count", div_code[7:4], e[7:4]);
            chk(n_code == e[15:8], interfere ? "R8 n after restart" : "R5 n_code",
                n_code, e[15:8]);
            chk(m_code == e[23:16],
                e[2] ? "R5 R7 m_code direct" : "R6 R7 m_code folded",
                m_code, e[23:16]);
            chk(div_code[3:0] == e[3:0], "R7 div low nibble", div_code[3:0], e[3:0]);
            @(negedge clk);
            chk(!done, "R3 done width", done, 0);
            repeat (5) @(negedge clk);
            chk({m_code, n_code, div_code} == e[23:0] && !range_err, "R9 codes hold",
                {m_code, n_code, div_code}, e[23:0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!done && !busy && !range_err, "R1 reset flags", {done, busy, range_err}, 0);
        chk(m_code == 0 && n_code == 0 && div_code == 0, "R1 reset codes",
            {m_code, n_code, div_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R1 idle after reset", {done, busy}, 0);

        run_case(32'd25175000, 1'b0, 32'd0);
        run_case(32'd0, 1'b0, 32'd0);
        run_case(32'd3124999, 1'b0, 32'd0);
        run_case(32'd3125000, 1'b0, 32'd0);
        run_case(32'd220000000, 1'b0, 32'd0);
        run_case(32'd220000001, 1'b0, 32'd0);
        run_case(32'hFFFF_FFFF, 1'b0, 32'd0);
        run_case(32'd100000000, 1'b0, 32'd0);
        run_case(32'd99999999, 1'b0, 32'd0);
        run_case(32'd50000000, 1'b0, 32'd0);
        run_case(32'd65000000, 1'b1, 32'd40000000);
        run_case(32'd143181800, 1'b0, 32'd0);
        for (int i = 0; i < 40; i++)
            run_case($urandom_range(32'd220000000, 32'd3125000), i[2], $urandom);
        for (int i = 0; i < 6; i++)
            run_case($urandom, 1'b0, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule